// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an 8-bit general-purpose I/O port that sits on a small register bus. It holds a direction register and an output data latch. From these it drives the tri-state controls of each pad, an output enable and an output value. It also samples the pad inputs through a two-flop synchronizer so that software can read the live pin levels.

Software reaches the port through two addresses. One is for data and one is for direction. Every write carries a per-bit mask, so a byte write and a single-bit set or clear use the same path. A data write is read-modify-write:

- Bits outside the mask take the value a data read would return at that moment.
- Bits inside the mask take the write data.
- The whole merged byte is stored in the latch.

Each pin has an analog-select input that forces the pin to read as zero. Pins 4 and 5 each have a peripheral override input that turns the digital driver off, whatever the direction bit holds.

Top module: `gpio_port`

## Requirements
- R1: A synchronous reset sets all eight direction bits to 1. After reset a direction read returns 0xFF and `pad_oe` is 0x00. The output latch is not reset.
- R2: One clock after the direction register or latch changes, `pad_oe[i]` equals the inverse of direction bit i (direction 0 means output), and `pad_out` equals the latch. This holds when no override is active.
- R3: A data read (`addr`=0) returns the pad levels through a two-flop synchronizer. A read strobed in the same cycle a pin changes still returns the old level. A read strobed two cycles later returns the new level.
- R4: On a data read, any bit whose `ana_sel` bit is 1 returns 0, whatever level is on the pin.
- R5: A data write changes only the latch, never the direction register. A later data read returns the pin levels, not the latch contents.
- R6: A data write is read-modify-write. The new latch is (read value AND NOT mask) OR (write data AND mask), so a one-bit mask sets or clears a single bit.
- R7: During a data write, an unmasked bit whose pin is analog-selected is stored as 0 in the latch.
- R8: A direction write (`addr`=1) changes only the direction bits selected by the mask. A direction read returns the stored bits exactly, unaffected by `ana_sel` and by the overrides.
- R9: While `ovr_en[0]` (pin 4) or `ovr_en[1]` (pin 5) is 1, that pin's `pad_oe` is 0 from the next clock on, regardless of its direction bit.
- R10: `ana_sel` has no effect on `pad_oe`. The direction bits alone control the drivers of analog-selected pins.
- R11: `rd_data` is registered one clock after a cycle with `rd_en`=1, and it holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | 0 selects data, 1 selects direction |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Bits to update on a write |
| rd_data | output | 8 | Registered read data |
| ana_sel | input | 8 | Per-pin analog select, 1 reads as zero |
| ovr_en | input | 2 | Peripheral override for pins 4 and 5 |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable, 1 drives |
| pad_out | output | 8 | Pad output value |

## Verification
The bench targets the read-modify-write path.

- It performs single-bit writes while the pins differ from the latch. A design that merged with the latch instead of the pins would leave stale bits in `pad_out`.
- It repeats the write with analog-selected pins. A design that skipped the zero mask in the merge would store ones there.
- It reads immediately after a pin change and again two cycles later. A synchronizer of the wrong depth shows up as a wrong value on one of these two reads.
- It reads direction back and watches `pad_oe` with overrides and analog selects active. This catches a design that let either input corrupt the stored direction or that ignored an override.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_DIR  = 1'b1
  } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  gpio_sel_e        sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic [WIDTH-1:0] pin_view,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] latch_q
);
  logic wr_dir, wr_dat;
  logic [WIDTH-1:0] dir_next, latch_next;

  assign wr_dir = wr_en && (sel == SEL_DIR);
  assign wr_dat = wr_en && (sel == SEL_DATA);

  // Direction merges with its own stored value.
  assign dir_next = (dir_q & ~wr_mask) | (wr_data & wr_mask);

  // Data merges with what a read would return (synchronized pins, analog zeroed).
  assign latch_next = (pin_view & ~wr_mask) | (wr_data & wr_mask);

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '1;
    else if (wr_dir) dir_q <= dir_next;
  end

  // The latch has no reset.
  always_ff @(posedge clk) begin
    if (wr_dat) latch_q <= latch_next;
  end

  p_dir_reset_r1: assert property (@(posedge clk) rst |=> (dir_q == '1))
    else $error("direction not all inputs after reset");

  p_dir_masked_r8: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> ((dir_q & ~$past(wr_mask)) == ($past(dir_q) & ~$past(wr_mask))))
    else $error("unmasked direction bit changed");

  p_dir_untouched_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_dir |=> $stable(dir_q))
    else $error("direction changed without a direction write");
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
  parameter int WIDTH   = 8,
  parameter int OVR_LO  = 4,
  parameter int OVR_NUM = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   dir_q,
  input  logic [WIDTH-1:0]   latch_q,
  input  logic [OVR_NUM-1:0] ovr_en,
  output logic [WIDTH-1:0]   pad_oe,
  output logic [WIDTH-1:0]   pad_out
);
  logic [WIDTH-1:0] ovr_mask;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      if (i >= OVR_LO && i < OVR_LO + OVR_NUM) begin : g_ovr
        assign ovr_mask[i] = ovr_en[i-OVR_LO];
      end else begin : g_plain
        assign ovr_mask[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= ~dir_q & ~ovr_mask;
      pad_out <= latch_q;
    end
  end

  genvar k;
  generate
    for (k = 0; k < OVR_NUM; k++) begin : g_chk
      p_ovr_off_r9: assert property (@(posedge clk) disable iff (rst)
        ovr_en[k] |=> !pad_oe[OVR_LO+k])
        else $error("override pin still driven");
    end
  endgenerate

  p_input_hiz_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(dir_q)) == '0))
    else $error("pin driven while direction is input");
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  gpio_sel_e        sel,
  input  logic [WIDTH-1:0] pins_sync,
  input  logic [WIDTH-1:0] ana_sel,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pin_view,
  output logic [WIDTH-1:0] rd_data
);
  assign pin_view = pins_sync & ~ana_sel;

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= (sel == SEL_DIR) ? dir_q : pin_view;
  end

  p_ana_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_DATA) |=> ((rd_data & $past(ana_sel)) == '0))
    else $error("analog pin read nonzero");

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data))
    else $error("read data moved without a strobe");
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int SYNC_LEN  = 2,
  parameter int OVR_LO    = 4,
  parameter int OVR_NUM   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic [WIDTH-1:0]   wr_mask,
  output logic [WIDTH-1:0]   rd_data,
  input  logic [WIDTH-1:0]   ana_sel,
  input  logic [OVR_NUM-1:0] ovr_en,
  input  logic [WIDTH-1:0]   pad_in,
  output logic [WIDTH-1:0]   pad_oe,
  output logic [WIDTH-1:0]   pad_out
);
  gpio_sel_e        sel;
  logic [WIDTH-1:0] pins_sync, pin_view, dir_q, latch_q;

  assign sel = gpio_sel_e'(addr);

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(pins_sync)
  );

  gpio_readback #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .pins_sync(pins_sync),
    .ana_sel(ana_sel), .dir_q(dir_q), .pin_view(pin_view), .rd_data(rd_data)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
    .wr_mask(wr_mask), .pin_view(pin_view), .dir_q(dir_q), .latch_q(latch_q)
  );

  gpio_padctl #(.WIDTH(WIDTH), .OVR_LO(OVR_LO), .OVR_NUM(OVR_NUM)) u_pad (
    .clk(clk), .rst(rst), .dir_q(dir_q), .latch_q(latch_q), .ovr_en(ovr_en),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic       clk = 1'b0;
  logic       rst, wr_en, rd_en, addr;
  logic [7:0] wr_data, wr_mask, rd_data, ana_sel, pad_in, pad_oe, pad_out;
  logic [1:0] ovr_en;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data), .ana_sel(ana_sel),
    .ovr_en(ovr_en), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic [7:0] m);
    addr = a; wr_data = d; wr_mask = m; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    rd(1'b1, v);
    check("R1 direction after reset", v, 8'hFF);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    pad_in = 8'hA5;
    rd(1'b0, v);
    check("R3 immediate read shows old level", v, 8'h00);
    idle(1);
    rd(1'b0, v);
    check("R3 delayed read shows new level", v, 8'hA5);
  endtask

  task automatic t_analog_read;
    logic [7:0] v;
    pad_in = 8'hFF; ana_sel = 8'h0F;
    idle(3);
    rd(1'b0, v);
    check("R4 analog pins read zero", v, 8'hF0);
    ana_sel = 8'h00;
  endtask

  task automatic t_rmw_set;
    logic [7:0] v;
    pad_in = 8'h3C;
    idle(3);
    wr(1'b0, 8'hFF, 8'h01);
    rd(1'b1, v);
    check("R5 data write leaves direction", v, 8'hFF);
    rd(1'b0, v);
    check("R5 data read returns pins", v, 8'h3C);
    wr(1'b1, 8'h00, 8'hFF);
    idle(1);
    check("R2 pad_oe follows direction", pad_oe, 8'hFF);
    check("R6 bit set merged with pins", pad_out, 8'h3D);
  endtask

  task automatic t_rmw_clear;
    pad_in = 8'hFF;
    idle(3);
    wr(1'b0, 8'h00, 8'h80);
    idle(1);
    check("R6 bit clear merged with pins", pad_out, 8'h7F);
  endtask

  task automatic t_rmw_analog;
    pad_in = 8'hFF; ana_sel = 8'hF0;
    idle(3);
    wr(1'b0, 8'h00, 8'h01);
    idle(1);
    check("R7 analog pins stored as zero", pad_out, 8'h0E);
    ana_sel = 8'h00;
  endtask

  task automatic t_dir_ovr;
    logic [7:0] v;
    wr(1'b1, 8'hFF, 8'h0C);
    ana_sel = 8'hFF; ovr_en = 2'b11;
    idle(2);
    rd(1'b1, v);
    check("R8 masked direction write and exact read", v, 8'h0C);
    check("R9 overrides disable pins 4 and 5", pad_oe, 8'hC3);
    ovr_en = 2'b01;
    idle(1);
    check("R9 single override on pin 4", pad_oe, 8'hE3);
    ovr_en = 2'b00;
    idle(1);
    check("R10 analog select leaves drivers alone", pad_oe, 8'hF3);
    ana_sel = 8'h00;
  endtask

  task automatic t_hold;
    logic [7:0] v;
    pad_in = 8'h5A;
    idle(3);
    rd(1'b0, v);
    check("R11 read data registered", v, 8'h5A);
    pad_in = 8'h11;
    idle(4);
    check("R11 read data holds without strobe", rd_data, 8'h5A);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0;
    wr_data = '0; wr_mask = '0; ana_sel = '0; ovr_en = '0; pad_in = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_sync();
    t_analog_read();
    t_rmw_set();
    t_rmw_clear();
    t_rmw_analog();
    t_dir_ovr();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule